// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block turns one packed 16-bit command word, a 24-bit address and a byte count into a complete single-lane SPI transaction with a serial flash device. A single start pulse sets the sequence going. The block pulls chip-select low and shifts out the opcode. It then sends the address bytes if the command word asks for them, followed by the requested number of dummy bytes. Last comes the data phase. In that phase the block either takes bytes from a streaming write input or hands each captured byte to a streaming read output. When the last byte is done, chip-select goes high again.

The serial link runs in SPI mode 0. The clock idles low and every frame is eight bits, most significant bit first. Each transmitted byte brings back one received byte in the same exchange. The serial clock is the system clock divided by a divisor that is latched at start. The integrating logic only has to build the command word and keep the data streams fed. It does not need to track individual bytes on the wire.

Top module: `flashseq_top`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, and busy, done, rd_valid and wr_ready are all 0.
- R2: A start pulse while idle drives spi_cs_n low and busy high from the next cycle. Both stay that way until release. At release, spi_cs_n goes high and busy goes low in the same cycle, and done is high for exactly that one cycle.
- R3: The first byte on spi_mosi is cmd_desc[7:0], sent MSB first in mode 0. spi_sclk idles low, the device samples on its rising edge, and spi_mosi does not change while spi_sclk is high.
- R4: When cmd_desc[11] is 1, three address bytes follow the opcode, most significant byte first. When it is 0, no address is sent.
- R5: cmd_desc[10:8] gives the number of dummy bytes (0 to 7) sent after the address phase. Each dummy byte is 0x00.
- R6: When cmd_desc[12] is 0 (read), the data phase sends cmd_len bytes of 0x00. Each byte received from spi_miso appears on rd_data with a one-cycle rd_valid pulse, in arrival order.
- R7: When cmd_desc[12] is 1 (write), a byte is taken from wr_data on each cycle where wr_valid and wr_ready are both 1, and the bytes go out in order. While wr_valid is low, the engine waits with spi_sclk low and chip-select held.
- R8: When cmd_len is 0, the transaction ends right after the dummy phase, with no rd_valid or wr_ready pulse.
- R9: One spi_sclk period lasts D system cycles, with the clock high for floor(D/2) of them. D is clk_div, latched at start. A clk_div of 0 or 1 selects the default of 6.
- R10: A start pulse while busy is ignored. The transaction in progress continues unchanged and no second transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| cmd_desc | input | 16 | Packed command word: opcode, dummy count, address flag, direction |
| cmd_addr | input | 24 | Flash address, sent MSB byte first |
| cmd_len | input | 16 | Number of data bytes |
| clk_div | input | 8 | Serial clock divisor (0 or 1 selects 6) |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte available |
| wr_ready | output | 1 | Write stream byte consumed this cycle |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte valid (one cycle) |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The bench goes after the points where phases meet. With the address flag clear, a design that still sends address bytes shifts every later byte, and the byte-by-byte wire comparison shows it. The same comparison catches a design that sends dummy bytes too early. A zero byte count must end right after the dummy bytes; a design that enters the data phase anyway shows an extra byte or a stray rd_valid or wr_ready. A maximum dummy count of seven with no address exposes an off-by-one in the dummy counter. An odd divisor and a divisor of zero (the default) check the high and low split of the serial clock. An edge rate or duty that is off shows up in the measured edge times. A write stream held invalid must freeze the wire with the clock low; a design that runs ahead moves the rising-edge count during the stall. A second start pulse in mid-transaction must leave the wire stream and the single done pulse untouched.

// File: rtl/flashseq_pkg.sv
package flashseq_pkg;

   typedef struct packed {
      logic       is_write;
      logic       has_addr;
      logic [2:0] n_dummy;
      logic [7:0] opcode;
   } fcmd_t;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_OPC   = 3'd1,
      S_ADDR  = 3'd2,
      S_DUMMY = 3'd3,
      S_DATA  = 3'd4,
      S_HOLD  = 3'd5
   } fstate_t;

   function automatic fcmd_t decode_cmd(input logic [12:0] w);
      fcmd_t c;
      c.opcode   = w[7:0];
      c.n_dummy  = w[10:8];
      c.has_addr = w[11];
      c.is_write = w[12];
      return c;
   endfunction

endpackage

// File: rtl/flashseq_bitclk.sv
module flashseq_bitclk #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             sclk_lvl,
   output logic             sample,
   output logic             bit_end
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] low_len;

   assign low_len  = div - (div >> 1);
   assign sclk_lvl = run && (cnt >= low_len);
   assign sample   = run && (cnt == low_len);
   assign bit_end  = run && (cnt == div - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart || !run) begin
         cnt <= '0;
      end else if (cnt == div - 1'b1) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/flashseq_shifter.sv
module flashseq_shifter #(
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] tx_byte,
   input  logic               sample,
   input  logic               bit_end,
   input  logic               miso,
   output logic               active,
   output logic               mosi,
   output logic               byte_done,
   output logic [FRAME_W-1:0] rx_byte
);
   localparam int BC_W = $clog2(FRAME_W);

   logic [FRAME_W-1:0] tx_sr;
   logic [FRAME_W-1:0] rx_sr;
   logic [FRAME_W-1:0] rx_next;
   logic [BC_W-1:0]    bitcnt;

   assign rx_next = sample ? {rx_sr[FRAME_W-2:0], miso} : rx_sr;
   assign mosi    = active ? tx_sr[FRAME_W-1] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         tx_sr     <= '0;
         rx_sr     <= '0;
         rx_byte   <= '0;
         bitcnt    <= '0;
         byte_done <= 1'b0;
      end else begin
         byte_done <= 1'b0;
         if (load) begin
            active <= 1'b1;
            tx_sr  <= tx_byte;
            bitcnt <= '0;
         end else if (active) begin
            rx_sr <= rx_next;
            if (bit_end) begin
               if (bitcnt == BC_W'(FRAME_W - 1)) begin
                  active    <= 1'b0;
                  byte_done <= 1'b1;
                  rx_byte   <= rx_next;
               end else begin
                  bitcnt <= bitcnt + 1'b1;
                  tx_sr  <= {tx_sr[FRAME_W-2:0], 1'b0};
               end
            end
         end
      end
   end
endmodule

// File: rtl/flashseq_ctl.sv
module flashseq_ctl
   import flashseq_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int CNT_W       = 16,
   parameter int DIV_W       = 8,
   parameter int DEFAULT_DIV = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [15:0]       cmd_desc,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [CNT_W-1:0]  cmd_len,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic [7:0]        wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              sh_load,
   output logic [7:0]        sh_byte,
   input  logic              sh_done,
   input  logic [7:0]        sh_rx,
   output logic [DIV_W-1:0]  div_q,
   output logic              cs_n,
   output logic              busy,
   output logic              done
);
   localparam int ADDR_BYTES = ADDR_W / 8;
   localparam int IDX_W      = 3;

   fstate_t          state;
   fcmd_t            cmd_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0] rem_q;
   logic [IDX_W-1:0] idx;
   logic             pend;
   logic             in_xfer;
   logic             data_wait;
   fstate_t          after_addr;
   fstate_t          after_dummy;
   logic [7:0]       abyte [ADDR_BYTES];
   logic             unused_desc_hi;

   assign unused_desc_hi = ^cmd_desc[15:13];

   for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
      assign abyte[g] = addr_q[ADDR_W-1-8*g -: 8];
   end

   assign in_xfer   = (state == S_OPC) || (state == S_ADDR) ||
                      (state == S_DUMMY) || (state == S_DATA);
   assign data_wait = (state == S_DATA) && cmd_q.is_write && !wr_valid;
   assign sh_load   = pend && in_xfer && !data_wait;
   assign wr_ready  = pend && (state == S_DATA) && cmd_q.is_write && wr_valid;
   assign rd_valid  = sh_done && (state == S_DATA) && !cmd_q.is_write;
   assign rd_data   = sh_rx;

   assign after_dummy = (rem_q != '0) ? S_DATA : S_HOLD;
   assign after_addr  = (cmd_q.n_dummy != 3'd0) ? S_DUMMY : after_dummy;

   always_comb begin
      case (state)
         S_OPC:   sh_byte = cmd_q.opcode;
         S_ADDR:  sh_byte = abyte[idx];
         S_DATA:  sh_byte = cmd_q.is_write ? wr_data : 8'h00;
         default: sh_byte = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         cmd_q  <= '0;
         addr_q <= '0;
         rem_q  <= '0;
         idx    <= '0;
         pend   <= 1'b0;
         div_q  <= DIV_W'(DEFAULT_DIV);
         cs_n   <= 1'b1;
         busy   <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (sh_load) pend <= 1'b0;
         case (state)
            S_IDLE: begin
               if (start) begin
                  cmd_q  <= decode_cmd(cmd_desc[12:0]);
                  addr_q <= cmd_addr;
                  rem_q  <= cmd_len;
                  div_q  <= (clk_div < DIV_W'(2)) ? DIV_W'(DEFAULT_DIV) : clk_div;
                  idx    <= '0;
                  pend   <= 1'b1;
                  cs_n   <= 1'b0;
                  busy   <= 1'b1;
                  state  <= S_OPC;
               end
            end
            S_OPC: begin
               if (sh_done) begin
                  idx <= '0;
                  if (cmd_q.has_addr) begin
                     state <= S_ADDR;
                     pend  <= 1'b1;
                  end else begin
                     state <= after_addr;
                     pend  <= (after_addr != S_HOLD);
                  end
               end
            end
            S_ADDR: begin
               if (sh_done) begin
                  if (idx == IDX_W'(ADDR_BYTES - 1)) begin
                     idx   <= '0;
                     state <= after_addr;
                     pend  <= (after_addr != S_HOLD);
                  end else begin
                     idx  <= idx + 1'b1;
                     pend <= 1'b1;
                  end
               end
            end
            S_DUMMY: begin
               if (sh_done) begin
                  if (idx == cmd_q.n_dummy - 1'b1) begin
                     idx   <= '0;
                     state <= after_dummy;
                     pend  <= (after_dummy != S_HOLD);
                  end else begin
                     idx  <= idx + 1'b1;
                     pend <= 1'b1;
                  end
               end
            end
            S_DATA: begin
               if (sh_done) begin
                  if (rem_q == CNT_W'(1)) begin
                     state <= S_HOLD;
                  end else begin
                     rem_q <= rem_q - 1'b1;
                     pend  <= 1'b1;
                  end
               end
            end
            S_HOLD: begin
               cs_n  <= 1'b1;
               busy  <= 1'b0;
               done  <= 1'b1;
               state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/flashseq_top.sv
module flashseq_top #(
   parameter int ADDR_W      = 24,
   parameter int CNT_W       = 16,
   parameter int DIV_W       = 8,
   parameter int DEFAULT_DIV = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [15:0]       cmd_desc,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [CNT_W-1:0]  cmd_len,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic [7:0]        wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              spi_sclk,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              busy,
   output logic              done
);
   if (ADDR_W % 8 != 0 || ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr
      $error("ADDR_W must be a multiple of 8 between 8 and 64");
   end
   if (DEFAULT_DIV < 2 || DEFAULT_DIV >= (1 << DIV_W)) begin : g_bad_div
      $error("DEFAULT_DIV must be at least 2 and fit in DIV_W bits");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be positive");
   end

   logic             sh_load;
   logic [7:0]       sh_byte;
   logic             sh_done;
   logic [7:0]       sh_rx;
   logic             sh_active;
   logic [DIV_W-1:0] div_q;
   logic             sample;
   logic             bit_end;

   flashseq_ctl #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .DEFAULT_DIV(DEFAULT_DIV)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_desc(cmd_desc),
      .cmd_addr(cmd_addr), .cmd_len(cmd_len), .clk_div(clk_div),
      .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .rd_data(rd_data), .rd_valid(rd_valid),
      .sh_load(sh_load), .sh_byte(sh_byte), .sh_done(sh_done), .sh_rx(sh_rx),
      .div_q(div_q), .cs_n(spi_cs_n), .busy(busy), .done(done)
   );

   flashseq_bitclk #(.DIV_W(DIV_W)) u_bitclk (
      .clk(clk), .rst_n(rst_n), .run(sh_active), .restart(sh_load),
      .div(div_q), .sclk_lvl(spi_sclk), .sample(sample), .bit_end(bit_end)
   );

   flashseq_shifter #(.FRAME_W(8)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(sh_load), .tx_byte(sh_byte),
      .sample(sample), .bit_end(bit_end), .miso(spi_miso),
      .active(sh_active), .mosi(spi_mosi), .byte_done(sh_done), .rx_byte(sh_rx)
   );
endmodule

// File: rtl/flashseq_checker.sv
module flashseq_checker (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic spi_cs_n,
   input logic spi_sclk,
   input logic spi_mosi,
   input logic rd_valid,
   input logic wr_ready
);
   assert_busy_tracks_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy == !spi_cs_n);

   assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_at_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (spi_cs_n && !busy));

   assert_cs_from_idle_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> ($past(start) && !$past(busy)));

   assert_mosi_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

   assert_sclk_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);

   assert_rd_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !spi_cs_n);

   assert_wr_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> !spi_cs_n);
endmodule

bind flashseq_top flashseq_checker u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
   .rd_valid(rd_valid), .wr_ready(wr_ready)
);

// File: tb/flashseq_top_tb.sv
`timescale 1ns/1ps
module flashseq_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] cmd_desc = '0;
   logic [23:0] cmd_addr = '0;
   logic [15:0] cmd_len = '0;
   logic [7:0]  clk_div = '0;
   logic [7:0]  wr_data = '0;
   logic        wr_valid = 1'b0;
   logic        wr_ready;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic        spi_sclk, spi_cs_n, spi_mosi;
   logic        spi_miso = 1'b0;
   logic        busy, done;

   int n_chk = 0;
   int n_bad = 0;

   flashseq_top u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_desc(cmd_desc),
      .cmd_addr(cmd_addr), .cmd_len(cmd_len), .clk_div(clk_div),
      .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .rd_data(rd_data), .rd_valid(rd_valid), .spi_sclk(spi_sclk),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .busy(busy), .done(done)
   );

   always #5 clk = ~clk;

   function automatic logic [7:0] resp(input int k);
      return 8'hC3 ^ 8'(k * 37);
   endfunction
   function automatic logic [7:0] wdat(input int k);
      return 8'h1B + 8'(k * 71);
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // device model: captures MOSI bytes, streams MISO bits
   logic [7:0] mosi_buf [64];
   int         mbits = 0;
   logic [7:0] cur = '0;
   int         sbit = 0;
   time        rise_t [2];
   time        fall_t = 0;
   int         nrise = 0;
   bit         fall_got = 0;

   always @(negedge spi_cs_n) begin
      sbit = 0;
      spi_miso = resp(0)[7];
   end
   always @(posedge spi_sclk) begin
      if (!spi_cs_n) begin
         cur = {cur[6:0], spi_mosi};
         mbits++;
         if (mbits % 8 == 0 && mbits / 8 <= 64) mosi_buf[mbits/8 - 1] = cur;
         if (nrise < 2) rise_t[nrise] = $time;
         nrise++;
      end
   end
   always @(negedge spi_sclk) begin
      if (!spi_cs_n) begin
         if (!fall_got) begin fall_t = $time; fall_got = 1; end
         sbit++;
         spi_miso = resp(sbit / 8)[7 - (sbit % 8)];
      end
   end

   // stream monitors
   logic [7:0] rd_buf [64];
   int rd_n = 0;
   int done_n = 0;
   int wi = 0;
   bit hs_q = 0;
   always @(negedge clk) begin
      if (rd_valid) begin
         if (rd_n < 64) rd_buf[rd_n] = rd_data;
         rd_n++;
      end
      if (done) begin
         done_n++;
         chk(spi_cs_n && !busy, "R2 release", {spi_cs_n, busy}, 2'b10);
      end
      if (hs_q) begin
         wi++;
         wr_data = wdat(wi);
      end
      hs_q = wr_valid && wr_ready;
   end

   task automatic run_txn(input logic [15:0] d, input logic [23:0] a, input int cnt,
                          input logic [7:0] div, input bit stall, input bit intrude,
                          input string tag);
      logic [7:0] exp [64];
      int n = 0;
      int hdr;
      int deff;
      int t;
      exp[n++] = d[7:0];
      if (d[11]) begin
         exp[n++] = a[23:16]; exp[n++] = a[15:8]; exp[n++] = a[7:0];
      end
      for (int i = 0; i < int'(d[10:8]); i++) exp[n++] = 8'h00;
      hdr = n;
      for (int i = 0; i < cnt; i++) exp[n++] = d[12] ? wdat(i) : 8'h00;
      deff = (div < 2) ? 6 : int'(div);

      @(negedge clk);
      mbits = 0; nrise = 0; fall_got = 0; rd_n = 0; done_n = 0; wi = 0;
      cmd_desc = d; cmd_addr = a; cmd_len = 16'(cnt); clk_div = div;
      wr_data = wdat(0); wr_valid = !stall;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy && !spi_cs_n, {tag, " R2 start"}, {busy, spi_cs_n}, 2'b10);
      clk_div = 8'd3;  // change after start must not matter (R9 latch)
      if (intrude) begin
         while (mbits < 4) @(negedge clk);
         cmd_desc = 16'h18FF; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      if (stall) begin
         while (mbits < hdr * 8) @(negedge clk);
         repeat (40) @(negedge clk);
         chk(mbits == hdr * 8 && !spi_sclk && !spi_cs_n && wi == 0,
             {tag, " R7 stall"}, mbits, hdr * 8);
         wr_valid = 1'b1;
      end
      t = 0;
      while (done_n == 0 && t < 30000) begin @(negedge clk); t++; end
      chk(done_n == 1, {tag, " R2 done"}, done_n, 1);
      repeat (60) @(negedge clk);
      chk(done_n == 1 && spi_cs_n, {tag, " R10 single txn"}, done_n, 1);
      wr_valid = 1'b0;
      chk(mbits == n * 8, {tag, " R4 R5 byte total"}, mbits, n * 8);
      for (int i = 0; i < n && i < 64; i++)
         chk(mosi_buf[i] == exp[i], {tag, " R3 R4 R5 wire byte"}, mosi_buf[i], exp[i]);
      if (d[12]) begin
         chk(wi == cnt, {tag, " R7 R8 write count"}, wi, cnt);
         chk(rd_n == 0, {tag, " R7 no read"}, rd_n, 0);
      end else begin
         chk(rd_n == cnt, {tag, " R6 R8 read count"}, rd_n, cnt);
         chk(wi == 0, {tag, " R6 no write"}, wi, 0);
         for (int i = 0; i < cnt && i < rd_n; i++)
            chk(rd_buf[i] == resp(hdr + i), {tag, " R6 read byte"}, rd_buf[i], resp(hdr + i));
      end
      chk((rise_t[1] - rise_t[0]) == time'(deff * 10), {tag, " R9 period"},
          rise_t[1] - rise_t[0], deff * 10);
      chk((fall_t - rise_t[0]) == time'((deff / 2) * 10), {tag, " R9 high time"},
          fall_t - rise_t[0], (deff / 2) * 10);
   endtask

   task automatic t_reset;
      chk(spi_cs_n && !spi_sclk && !busy && !done && !rd_valid && !wr_ready,
          "R1 reset", {spi_cs_n, spi_sclk, busy, done, rd_valid, wr_ready}, 6'b100000);
   endtask
   task automatic t_status_default_div;
      run_txn(16'h0005, 24'h0, 1, 8'd0, 0, 0, "status");
   endtask
   task automatic t_read_addr;
      run_txn(16'h0803, 24'h123456, 4, 8'd4, 0, 0, "read");
   endtask
   task automatic t_read_dummy_odd_div;
      run_txn(16'h095A, 24'h00A5F0, 2, 8'd5, 0, 0, "sfdp");
   endtask
   task automatic t_write_page;
      run_txn(16'h1802, 24'hABCDEF, 3, 8'd2, 0, 0, "program");
   endtask
   task automatic t_opcode_only;
      run_txn(16'h0006, 24'hFFFFFF, 0, 8'd3, 0, 0, "R8 opcode only");
   endtask
   task automatic t_max_dummy;
      run_txn(16'h0720, 24'h0, 0, 8'd1, 0, 0, "R5 R8 max dummy");
   endtask
   task automatic t_write_stall;
      run_txn(16'h1A02, 24'h010203, 2, 8'd4, 1, 0, "stall");
   endtask
   task automatic t_start_busy;
      run_txn(16'h0803, 24'h0F0E0D, 2, 8'd2, 0, 1, "R10 busy start");
   endtask

   initial begin
      #1500000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_status_default_div();
      t_read_addr();
      t_read_dummy_odd_div();
      t_write_page();
      t_opcode_only();
      t_max_dummy();
      t_write_stall();
      t_start_busy();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule